// File: doc/BRIEF.md
# Accumulator Rounding Unit with Selectable Tie Bias

This block rounds a 40-bit multiply-accumulate result down to its 16-bit middle word. The value is treated as three fields: an 8-bit guard byte on top, the 16-bit middle word that carries the useful result, and a 16-bit fraction word below it. Rounding adds half of one middle-word LSB. Any carry ripples through the middle word into the guard byte. The fraction word leaves the block unchanged.

A mode bit selects what happens on an exact tie, that is, when the fraction word is exactly half. In unbiased mode a tie goes to the even middle word (round-half-to-even). In biased mode a tie always rounds up. The mode bit is bit 12 of a 16-bit control register that can be written and read back. The other 15 bits of that register are stored but change nothing.

A caller presents the value and pulses the round strobe. One clock later the rounded value is available with a valid flag. The registered result holds until the next strobe.

Top module: `acc_round_unit`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, `rnd_out` is 0, `rnd_valid` is 0 and `cfg_rd_data` is 0. The default mode is therefore unbiased.
- R2: `rnd_valid` is 1 in exactly those cycles that directly follow a cycle with `rnd_en` high. The strobe may stay high on consecutive cycles. `rnd_out` keeps its value when no strobe is given.
- R3: Bits 15:0 of `rnd_out` equal bits 15:0 of the `acc_in` value that was sampled with the strobe.
- R4: If the fraction word (bits 15:0) is below 0x8000, bits 39:16 are unchanged. If it is above 0x8000, bits 39:16 are incremented by one. Both modes behave this way.
- R5: In unbiased mode (control bit 12 = 0), a fraction word of exactly 0x8000 increments bits 39:16 only when bit 16 is 1. Otherwise bits 39:16 are unchanged.
- R6: In biased mode (control bit 12 = 1), a fraction word of exactly 0x8000 always increments bits 39:16.
- R7: The increment carries from the middle word into the guard byte (bits 39:32). It wraps modulo 2^40 with no saturation. For example, 0xFF_FFFF_8001 gives 0x00_0000_8001.
- R8: A write with `cfg_wr_en` stores all 16 bits of `cfg_wr_data`, and they read back on `cfg_rd_data` from the next cycle. Only bit 12 affects rounding.
- R9: A strobe uses the mode held in the control register at that clock edge. A write in the same cycle takes effect only from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_in | input | 40 | Accumulator value to round (guard, middle, fraction) |
| rnd_en | input | 1 | Round strobe, samples `acc_in` |
| cfg_wr_en | input | 1 | Control register write enable |
| cfg_wr_data | input | 16 | Control register write data |
| cfg_rd_data | output | 16 | Control register contents |
| rnd_out | output | 40 | Registered rounded value |
| rnd_valid | output | 1 | High the cycle after a strobe |

## Verification
The hardest case to reach from the ports is the exact tie combined with carries that cross field boundaries. An all-ones middle word with a tie in biased mode must carry into the guard byte. With an all-ones guard byte as well, the result must wrap to zero.

The bench sweeps a grid of guard bytes, middle words of both parities, and fraction words at and around 0x8000, in both modes. It issues back-to-back strobes and compares each result with an arithmetic model. A mode write issued in the same cycle as a tie strobe exposes which mode the strobe actually used.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;

  typedef enum logic {
    RND_UNBIASED = 1'b0,
    RND_BIASED   = 1'b1
  } rnd_mode_e;

  localparam int unsigned DEF_TOP_W  = 8;
  localparam int unsigned DEF_MID_W  = 16;
  localparam int unsigned DEF_LOW_W  = 16;
  localparam int unsigned DEF_CTRL_W = 16;
  localparam int unsigned DEF_MODE_BIT = 12;

endpackage

// File: rtl/acc_round_rst_sync.sv
module acc_round_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/acc_round_cfg.sv
module acc_round_cfg
  import acc_round_pkg::*;
#(
  parameter int unsigned CTRL_W   = DEF_CTRL_W,
  parameter int unsigned MODE_BIT = DEF_MODE_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output rnd_mode_e         mode_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign rd_data_o = ctrl_q;
  assign mode_o    = rnd_mode_e'(ctrl_q[MODE_BIT]);

  // R8: a write lands in full on the next cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  // R8: without a write the register keeps its contents
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/acc_round_core.sv
module acc_round_core
  import acc_round_pkg::*;
#(
  parameter int unsigned TOP_W = DEF_TOP_W,
  parameter int unsigned MID_W = DEF_MID_W,
  parameter int unsigned LOW_W = DEF_LOW_W
) (
  input  logic [TOP_W+MID_W+LOW_W-1:0] acc_i,
  input  rnd_mode_e                    mode_i,
  output logic [TOP_W+MID_W+LOW_W-1:0] res_o
);

  localparam int unsigned ACC_W = TOP_W + MID_W + LOW_W;
  localparam int unsigned UP_W  = TOP_W + MID_W;

  logic [LOW_W-1:0] frac;
  logic [UP_W-1:0]  upper;
  logic [UP_W-1:0]  upper_inc;
  logic             half_bit;
  logic             sticky;
  logic             round_up;

  always_comb begin
    frac     = acc_i[LOW_W-1:0];
    upper    = acc_i[ACC_W-1:LOW_W];
    half_bit = frac[LOW_W-1];
    sticky   = |frac[LOW_W-2:0];
    // tie: half set, nothing below it; bias forces up, else go to even
    round_up = half_bit & (sticky | (mode_i == RND_BIASED) | upper[0]);
    upper_inc = upper + UP_W'(round_up);
    res_o    = {upper_inc, frac};
  end

endmodule

// File: rtl/acc_round_pipe.sv
module acc_round_pipe #(
  parameter int unsigned DATA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;
  logic              valid_q;
  logic              valid_d;

  always_comb begin
    data_d  = data_q;
    valid_d = load_i;
    if (load_i) begin
      data_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_i) begin
        data_q <= data_d;
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R2: valid follows the strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o);
  a_r2_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> !valid_o);
  // R2: the result holds without a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(data_o));

endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit
  import acc_round_pkg::*;
#(
  parameter int unsigned TOP_W    = DEF_TOP_W,
  parameter int unsigned MID_W    = DEF_MID_W,
  parameter int unsigned LOW_W    = DEF_LOW_W,
  parameter int unsigned CTRL_W   = DEF_CTRL_W,
  parameter int unsigned MODE_BIT = DEF_MODE_BIT
) (
  input  logic                         clk,
  input  logic                         arst_n,
  input  logic [TOP_W+MID_W+LOW_W-1:0] acc_in,
  input  logic                         rnd_en,
  input  logic                         cfg_wr_en,
  input  logic [CTRL_W-1:0]            cfg_wr_data,
  output logic [CTRL_W-1:0]            cfg_rd_data,
  output logic [TOP_W+MID_W+LOW_W-1:0] rnd_out,
  output logic                         rnd_valid
);

  localparam int unsigned ACC_W = TOP_W + MID_W + LOW_W;
  localparam logic [LOW_W-1:0] HALF = {1'b1, {(LOW_W-1){1'b0}}};

  logic             rst_n;
  rnd_mode_e        mode;
  logic [ACC_W-1:0] rounded;

  acc_round_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  acc_round_cfg #(.CTRL_W(CTRL_W), .MODE_BIT(MODE_BIT)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_wr_en),
    .wr_data_i (cfg_wr_data),
    .rd_data_o (cfg_rd_data),
    .mode_o    (mode)
  );

  acc_round_core #(.TOP_W(TOP_W), .MID_W(MID_W), .LOW_W(LOW_W)) u_core (
    .acc_i  (acc_in),
    .mode_i (mode),
    .res_o  (rounded)
  );

  acc_round_pipe #(.DATA_W(ACC_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rnd_en),
    .data_i  (rounded),
    .data_o  (rnd_out),
    .valid_o (rnd_valid)
  );

  // R3: fraction word passes through
  a_r3_frac_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_en |=> rnd_out[LOW_W-1:0] == $past(acc_in[LOW_W-1:0]));

  // R4: below half leaves the upper part untouched
  a_r4_below_half: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_en && !acc_in[LOW_W-1]) |=>
      rnd_out[ACC_W-1:LOW_W] == $past(acc_in[ACC_W-1:LOW_W]));

  // R6: biased tie always steps up by one
  a_r6_bias_tie_up: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_en && mode == RND_BIASED && acc_in[LOW_W-1:0] == HALF) |=>
      rnd_out[ACC_W-1:LOW_W] == $past(acc_in[ACC_W-1:LOW_W]) + 1'b1);

  // R5: unbiased tie leaves an even result
  a_r5_tie_even: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_en && mode == RND_UNBIASED && acc_in[LOW_W-1:0] == HALF) |=>
      !rnd_out[LOW_W]);

endmodule

// File: tb/acc_round_unit_tb.sv
module acc_round_unit_tb_top;

  logic        clk;
  logic        arst_n;
  logic [39:0] acc_in;
  logic        rnd_en;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_data;
  logic [15:0] cfg_rd_data;
  logic [39:0] rnd_out;
  logic        rnd_valid;

  int checks;
  int errors;
  int cycles;
  bit done;

  acc_round_unit dut_i (
    .clk         (clk),
    .arst_n      (arst_n),
    .acc_in      (acc_in),
    .rnd_en      (rnd_en),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .rnd_out     (rnd_out),
    .rnd_valid   (rnd_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected value: add half, clear LSB of the upper part on an unbiased tie
  function automatic logic [39:0] model(logic [39:0] a, bit biased);
    logic [40:0] sum;
    logic [23:0] up;
    sum = {1'b0, a} + 41'h8000;
    up  = sum[39:16];
    if (!biased && a[15:0] == 16'h8000) up[0] = 1'b0;
    return {up, a[15:0]};
  endfunction

  function automatic string tag_of(logic [39:0] a, bit biased);
    if (a[15:0] > 16'h8000 && a[39:16] == 24'hFFFFFF) return "R7";
    if (a[15:0] != 16'h8000) return "R4";
    if (a[39:16] == 24'hFFFFFF && biased) return "R7";
    return biased ? "R6" : "R5";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic write_cfg(logic [15:0] v);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mid_pick(int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;
      2: return 16'h0002;  3: return 16'h0003;
      4: return 16'h7FFE;  5: return 16'h7FFF;
      6: return 16'hFFFE;  default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] low_pick(int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;
      2: return 16'h7FFE;  3: return 16'h7FFF;
      4: return 16'h8000;  5: return 16'h8001;
      6: return 16'h8002;  7: return 16'hC000;
      default: return 16'hFFFF;
    endcase
  endfunction

  // back-to-back strobes over a grid, checked one cycle later
  task automatic sweep(bit biased);
    logic [39:0] prev;
    bit have;
    have = 1'b0;
    prev = '0;
    for (int t = 0; t < 3; t++) begin
      for (int m = 0; m < 8; m++) begin
        for (int l = 0; l < 9; l++) begin
          logic [7:0] top;
          top = (t == 0) ? 8'h00 : (t == 1) ? 8'h7F : 8'hFF;
          acc_in = {top, mid_pick(m), low_pick(l)};
          rnd_en = 1'b1;
          @(negedge clk);
          if (have) ;
          check("R2", {63'd0, rnd_valid}, 64'd1);
          check(tag_of(acc_in, biased), {24'd0, rnd_out}, {24'd0, model(acc_in, biased)});
          check("R3", {48'd0, rnd_out[15:0]}, {48'd0, acc_in[15:0]});
          prev = acc_in;
          have = 1'b1;
        end
      end
    end
    rnd_en = 1'b0;
    @(negedge clk);
    check("R2", {63'd0, rnd_valid}, 64'd0);
    check("R2", {24'd0, rnd_out}, {24'd0, model(prev, biased)});
  endtask

  task automatic one_round(logic [39:0] a);
    acc_in = a;
    rnd_en = 1'b1;
    @(negedge clk);
    rnd_en = 1'b0;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_sim();
      end
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    arst_n = 1'b0; rnd_en = 1'b0; cfg_wr_en = 1'b0;
    cfg_wr_data = '0; acc_in = 40'h12_3456_8000;
    repeat (3) @(negedge clk);
    check("R1", {24'd0, rnd_out}, 64'd0);
    check("R1", {63'd0, rnd_valid}, 64'd0);
    check("R1", {48'd0, cfg_rd_data}, 64'd0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {24'd0, rnd_out}, 64'd0);
    check("R1", {63'd0, rnd_valid}, 64'd0);
    check("R1", {48'd0, cfg_rd_data}, 64'd0);

    // default mode is unbiased: even tie stays
    one_round(40'h00_0000_8000);
    check("R5", {24'd0, rnd_out}, 64'h00_0000_8000);
    check("R2", {63'd0, rnd_valid}, 64'd1);
    @(negedge clk);
    check("R2", {63'd0, rnd_valid}, 64'd0);
    acc_in = 40'hAA_AAAA_AAAA;
    @(negedge clk);
    check("R2", {24'd0, rnd_out}, 64'h00_0000_8000);

    sweep(1'b0);

    // R8: all bits read back, bits other than 12 inert
    write_cfg(16'hEFFF);
    check("R8", {48'd0, cfg_rd_data}, 64'hEFFF);
    one_round(40'h00_0000_8000);
    check("R8", {24'd0, rnd_out}, 64'h00_0000_8000);
    write_cfg(16'h1000);
    check("R8", {48'd0, cfg_rd_data}, 64'h1000);

    sweep(1'b1);

    // R7 explicit wrap cases
    one_round(40'hFF_FFFF_8001);
    check("R7", {24'd0, rnd_out}, 64'h00_0000_8001);
    one_round(40'h00_FFFF_8000);
    check("R7", {24'd0, rnd_out}, 64'h01_0000_8000);

    // R9: write clearing the mode in the strobe cycle; old (biased) mode applies
    acc_in = 40'h00_0000_8000;
    rnd_en = 1'b1;
    cfg_wr_en = 1'b1;
    cfg_wr_data = 16'h0000;
    @(negedge clk);
    rnd_en = 1'b0;
    cfg_wr_en = 1'b0;
    check("R9", {24'd0, rnd_out}, 64'h00_0001_8000);
    one_round(40'h00_0000_8000);
    check("R9", {24'd0, rnd_out}, 64'h00_0000_8000);
    // and setting it in the strobe cycle: old (unbiased) mode applies
    acc_in = 40'h00_0002_8000;
    rnd_en = 1'b1;
    cfg_wr_en = 1'b1;
    cfg_wr_data = 16'h1000;
    @(negedge clk);
    rnd_en = 1'b0;
    cfg_wr_en = 1'b0;
    check("R9", {24'd0, rnd_out}, 64'h00_0002_8000);
    one_round(40'h00_0002_8000);
    check("R6", {24'd0, rnd_out}, 64'h00_0003_8000);

    finish_sim();
  end

endmodule